// File: doc/BRIEF.md
# Synthesiser Serial Control Slave

This block is the control-side serial slave of a tuning frequency synthesiser. It watches an oversampled I2C clock/data pair, answers to one of four device addresses chosen by a two-bit strap input, and holds the programmed state of the synthesiser: a 15-bit loop divide ratio, a 7-bit control field (pump current, test selects, output disables) and a 4-bit output-port drive field. The data line is driven only as an open-drain pull-down enable.

In write mode the master may stream any number of two-byte pairs after a single address. The top bit of the first byte of each pair picks the pair type: divider pair or control/port pair. In read mode the slave returns a status byte built from its power-on flag, a lock indication, three port input levels and a 3-bit code derived from a four-comparator level bank. The analog address-strap decoder, the comparators and the lock detector live outside; their digital results arrive as inputs.

Top module: `synth_i2c_ctrl`

## Requirements
- R1: The slave acknowledges an address byte (MSB first) equal to 1,1,0,0,0,S1,S0,D where S1 S0 equal `addr_sel_i[1:0]` and D is the direction (0 write, 1 read); any other address gets no acknowledge, and the bytes that follow it change no output.
- R2: In a write session every received data byte is acknowledged by pulling SDA low during the ninth clock.
- R3: A first-of-pair byte with bit 7 = 0 supplies divide-ratio bits 14..8 from its bits 6..0; the next byte supplies bits 7..0, and `div_ratio_o` changes once, to the full 15-bit value, only when that second byte is accepted.
- R4: A first-of-pair byte with bit 7 = 1 loads its bits 6..0 into `ctrl_o`; the next byte loads its bits 7..4 into `port_drv_o[3:0]` (bit 7 to `port_drv_o[3]`).
- R5: Pairs may follow one another without re-addressing; a START (including a repeated START) makes the next data byte a first-of-pair byte again.
- R6: A transfer ended by STOP before a byte is complete leaves every output register unchanged, including a divide ratio whose upper byte was already accepted.
- R7: The read status byte is, MSB to LSB: power-on flag, `lock_i`, `port_lvl_i[2]`, `port_lvl_i[1]`, `port_lvl_i[0]`, then the 3-bit level code.
- R8: The level code is the index plus one of the highest asserted bit of `adc_cmp_i` (1xxx gives 100, 01xx gives 011, 001x gives 010, 0001 gives 001, 0000 gives 000).
- R9: In a read session an acknowledge from the master after a status byte brings another status byte; a not-acknowledge ends the session as a STOP would, and the slave drives SDA no more until the next START.
- R10: Reset sets the power-on flag and clears the divide ratio, control field and port drive (all ports off); the flag is cleared only when a read session ends (by STOP or by a not-acknowledge), never by the end of a write session.
- R11: The SDA pull-down changes state only right after a detected SCL falling edge, START or STOP, never while SCL is stably high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial bus |
| rst_ni | input | 1 | Asynchronous active-low reset (power-on event) |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| addr_sel_i | input | 2 | Strapped low address bits |
| lock_i | input | 1 | Loop lock indication |
| port_lvl_i | input | 3 | Sensed port input levels for the status byte |
| adc_cmp_i | input | 4 | Level comparator outputs, bit 0 lowest threshold |
| div_ratio_o | output | 15 | Active loop divide ratio |
| ctrl_o | output | 7 | Control field from the control byte |
| port_drv_o | output | 4 | Output port drive, 1 = port on |

## Verification
The bound checker watches, on every cycle, that the data-line pull-down moves only after an SCL fall, START or STOP, that the divide ratio, control and port registers change only right after an accepted byte and never two register groups at once, and that the power-on flag drops only when a read session has just ended. Address matching under every strap setting, the pair steering and its restart on a repeated START, the discard of truncated bytes, the status layout and level encoding, multi-byte reads and the silence after a not-acknowledge can only be shown by the bench's bus transactions.

// File: rtl/synth_i2c_pkg.sv
`timescale 1ns/1ps
package synth_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } bus_state_e;

  typedef enum logic [1:0] {PT_FIRST, PT_DIV_LO, PT_PORT} pair_ptr_e;

  localparam logic [4:0] DEV_ADDR_HI = 5'b11000;
endpackage

// File: rtl/synth_i2c_cond.sv
`timescale 1ns/1ps
module synth_i2c_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_d, sda_d, scl_s;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scl_sync[g] <= 1'b1;
        sda_sync[g] <= 1'b1;
      end else begin
        scl_sync[g] <= (g == 0) ? scl_i : scl_sync[(g == 0) ? 0 : g-1];
        sda_sync[g] <= (g == 0) ? sda_i : sda_sync[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign scl_s = scl_sync[SYNC_STAGES-1];
  assign sda_o = sda_sync[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_o;
    end
  end

  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // data edges with clock held high mark bus conditions
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/synth_i2c_bit_fsm.sv
`timescale 1ns/1ps
module synth_i2c_bit_fsm
  import synth_i2c_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       sda_i,
  input  logic [1:0] addr_sel_i,
  input  logic [7:0] status_i,
  output logic       sda_oe_o,
  output logic       byte_stb_o,
  output logic [7:0] byte_o,
  output logic       rd_end_o
);
  bus_state_e state_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q, tx_q;
  logic       rw_q, rd_sess_q;

  assign byte_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      rw_q       <= 1'b0;
      rd_sess_q  <= 1'b0;
      sda_oe_o   <= 1'b0;
      byte_stb_o <= 1'b0;
      rd_end_o   <= 1'b0;
    end else begin
      byte_stb_o <= 1'b0;
      rd_end_o   <= 1'b0;
      if (start_i) begin
        state_q   <= ST_ADDR;
        cnt_q     <= '0;
        sda_oe_o  <= 1'b0;
        rd_sess_q <= 1'b0;
      end else if (stop_i) begin
        state_q   <= ST_IDLE;
        sda_oe_o  <= 1'b0;
        rd_end_o  <= rd_sess_q;
        rd_sess_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              cnt_q <= '0;
              if (state_q == ST_WR) begin
                byte_stb_o <= 1'b1;
                sda_oe_o   <= 1'b1;
                state_q    <= ST_WR_ACK;
              end else if (sh_q[7:3] == DEV_ADDR_HI && sh_q[2:1] == addr_sel_i) begin
                sda_oe_o  <= 1'b1;
                rw_q      <= sh_q[0];
                rd_sess_q <= sh_q[0];
                state_q   <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            if (rw_q) begin
              tx_q     <= status_i;
              sda_oe_o <= ~status_i[7];
              state_q  <= ST_RD;
            end else begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_WR;
            end
          end
          ST_WR_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            state_q  <= ST_WR;
          end
          ST_RD: begin
            if (scl_rise_i) cnt_q <= cnt_q + 4'd1;
            else if (scl_fall_i) begin
              if (cnt_q == 4'd8) begin
                cnt_q    <= '0;
                sda_oe_o <= 1'b0;
                state_q  <= ST_RD_ACK;
              end else begin
                sda_oe_o <= ~tx_q[3'd7 - cnt_q[2:0]];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i && sda_i) begin
              // master declined: behave as a stop
              state_q   <= ST_IDLE;
              rd_end_o  <= 1'b1;
              rd_sess_q <= 1'b0;
            end else if (scl_fall_i) begin
              tx_q     <= status_i;
              sda_oe_o <= ~status_i[7];
              state_q  <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/synth_i2c_regs.sv
`timescale 1ns/1ps
module synth_i2c_regs
  import synth_i2c_pkg::*;
#(
  parameter int unsigned DIV_W     = 15,
  parameter int unsigned ADC_CMP_N = 4,
  localparam int unsigned HI_W     = DIV_W - 8,
  localparam int unsigned CODE_W   = $clog2(ADC_CMP_N + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 byte_stb_i,
  input  logic [7:0]           byte_i,
  input  logic                 rd_end_i,
  input  logic                 lock_i,
  input  logic [2:0]           port_lvl_i,
  input  logic [ADC_CMP_N-1:0] adc_cmp_i,
  output logic [DIV_W-1:0]     div_ratio_o,
  output logic [6:0]           ctrl_o,
  output logic [3:0]           port_drv_o,
  output logic [7:0]           status_o,
  output logic                 por_o
);
  pair_ptr_e        ptr_q;
  logic [HI_W-1:0]  div_hi_q;
  logic [CODE_W-1:0] code;

  always_comb begin
    code = '0;
    for (int i = 0; i < ADC_CMP_N; i++)
      if (adc_cmp_i[i]) code = CODE_W'(i + 1);
  end

  assign status_o = {por_o, lock_i, port_lvl_i, code};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= PT_FIRST;
      div_hi_q    <= '0;
      div_ratio_o <= '0;
      ctrl_o      <= '0;
      port_drv_o  <= '0;
      por_o       <= 1'b1;
    end else begin
      if (rd_end_i) por_o <= 1'b0;
      if (start_i) ptr_q <= PT_FIRST;
      else if (byte_stb_i) begin
        unique case (ptr_q)
          PT_FIRST: begin
            if (byte_i[7]) begin
              ctrl_o <= byte_i[6:0];
              ptr_q  <= PT_PORT;
            end else begin
              div_hi_q <= byte_i[HI_W-1:0];
              ptr_q    <= PT_DIV_LO;
            end
          end
          PT_DIV_LO: begin
            div_ratio_o <= {div_hi_q, byte_i};
            ptr_q       <= PT_FIRST;
          end
          PT_PORT: begin
            port_drv_o <= byte_i[7:4];
            ptr_q      <= PT_FIRST;
          end
          default: ptr_q <= PT_FIRST;
        endcase
      end
    end
  end
endmodule

// File: rtl/synth_i2c_ctrl.sv
`timescale 1ns/1ps
module synth_i2c_ctrl #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_W       = 15,
  parameter int unsigned ADC_CMP_N   = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic [1:0]           addr_sel_i,
  input  logic                 lock_i,
  input  logic [2:0]           port_lvl_i,
  input  logic [ADC_CMP_N-1:0] adc_cmp_i,
  output logic [DIV_W-1:0]     div_ratio_o,
  output logic [6:0]           ctrl_o,
  output logic [3:0]           port_drv_o
);
  logic scl_rise_w, scl_fall_w, start_w, stop_w, sda_w;
  logic byte_stb_w, rd_end_w, por_w;
  logic [7:0] byte_w, status_w;

  synth_i2c_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise_w), .scl_fall_o(scl_fall_w),
    .start_o(start_w), .stop_o(stop_w), .sda_o(sda_w)
  );

  synth_i2c_bit_fsm u_fsm (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise_w), .scl_fall_i(scl_fall_w),
    .start_i(start_w), .stop_i(stop_w), .sda_i(sda_w),
    .addr_sel_i, .status_i(status_w),
    .sda_oe_o, .byte_stb_o(byte_stb_w), .byte_o(byte_w), .rd_end_o(rd_end_w)
  );

  synth_i2c_regs #(.DIV_W(DIV_W), .ADC_CMP_N(ADC_CMP_N)) u_regs (
    .clk_i, .rst_ni,
    .start_i(start_w), .byte_stb_i(byte_stb_w), .byte_i(byte_w),
    .rd_end_i(rd_end_w), .lock_i, .port_lvl_i, .adc_cmp_i,
    .div_ratio_o, .ctrl_o, .port_drv_o,
    .status_o(status_w), .por_o(por_w)
  );
endmodule

// File: rtl/synth_i2c_ctrl_chk.sv
`timescale 1ns/1ps
module synth_i2c_ctrl_chk #(
  parameter int unsigned DIV_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sda_oe_o,
  input logic [DIV_W-1:0] div_ratio_o,
  input logic [6:0]       ctrl_o,
  input logic [3:0]       port_drv_o,
  input logic             scl_fall_w,
  input logic             start_w,
  input logic             stop_w,
  input logic             byte_stb_w,
  input logic             rd_end_w,
  input logic             por_w
);
  assert_sda_edge_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> $past(scl_fall_w || start_w || stop_w));

  assert_div_commit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_ratio_o) |-> $past(byte_stb_w));

  assert_ctrl_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> $past(byte_stb_w));

  assert_port_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(port_drv_o) |-> $past(byte_stb_w));

  assert_single_group_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!$stable(div_ratio_o) && !$stable(ctrl_o)));

  assert_por_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(por_w) |-> $past(rd_end_w));
endmodule

bind synth_i2c_ctrl synth_i2c_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_o(sda_oe_o),
  .div_ratio_o(div_ratio_o), .ctrl_o(ctrl_o), .port_drv_o(port_drv_o),
  .scl_fall_w(scl_fall_w), .start_w(start_w), .stop_w(stop_w),
  .byte_stb_w(byte_stb_w), .rd_end_w(rd_end_w), .por_w(por_w)
);

// File: tb/synth_i2c_ctrl_tb.sv
`timescale 1ns/1ps
module synth_i2c_ctrl_tb;
  localparam int Q = 5;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] addr_sel = 2'd0;
  logic lock = 1'b0;
  logic [2:0] port_lvl = 3'd0;
  logic [3:0] adc_cmp = 4'd0;
  logic sda_oe;
  logic [14:0] div_ratio;
  logic [6:0] ctrl;
  logic [3:0] port_drv;
  wire sda_line = m_sda & ~sda_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  synth_i2c_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .lock_i(lock),
    .port_lvl_i(port_lvl), .adc_cmp_i(adc_cmp),
    .div_ratio_o(div_ratio), .ctrl_o(ctrl), .port_drv_o(port_drv)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(H/2); b = sda_line;
    tick(H/2); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(H); m_sda = 1'b0; tick(H);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(H); m_sda = 1'b1; tick(H);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic rd_byte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(nack);
  endtask

  function automatic logic [7:0] adr(input logic [1:0] ma, input logic rd);
    return {5'b11000, ma, rd};
  endfunction

  function automatic logic [2:0] lvl_code(input logic [3:0] c);
    logic [2:0] r = 3'd0;
    for (int i = 0; i < 4; i++) if (c[i]) r = 3'(i + 1);
    return r;
  endfunction

  function automatic logic [7:0] exp_status(input logic p, input logic l,
                                            input logic [2:0] pl, input logic [3:0] c);
    return {p, l, pl, lvl_code(c)};
  endfunction

  task automatic write_div(input logic [14:0] v);
    logic a0, a1, a2;
    bus_start(); wr_byte(adr(addr_sel, 1'b0), a0);
    wr_byte({1'b0, v[14:8]}, a1); wr_byte(v[7:0], a2); bus_stop();
    chk("R2 acks", {29'd0, a0, a1, a2}, 32'd7);
    chk("R3 divide ratio", {17'd0, div_ratio}, {17'd0, v});
  endtask

  task automatic read_one(output logic [7:0] d);
    logic a;
    bus_start(); wr_byte(adr(addr_sel, 1'b1), a);
    rd_byte(1'b1, d); bus_stop();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic a, b0, b1;
    logic [7:0] d, d2;
    tick(4); rst_n = 1'b1; tick(4);

    // R10 reset state
    chk("R10 div reset", {17'd0, div_ratio}, 32'd0);
    chk("R10 ctrl reset", {25'd0, ctrl}, 32'd0);
    chk("R10 ports off", {28'd0, port_drv}, 32'd0);
    chk("R11 sda idle", {31'd0, sda_oe}, 32'd0);

    // R1 address sweep over strap and address bits
    for (int s = 0; s < 4; s++) begin
      addr_sel = 2'(s);
      for (int m = 0; m < 4; m++) begin
        bus_start(); wr_byte(adr(2'(m), 1'b0), a); bus_stop();
        chk("R1 address ack", {31'd0, a}, {31'd0, (m == s)});
      end
    end
    addr_sel = 2'd2;
    bus_start(); wr_byte(8'b1001_0100, a);
    wr_byte(8'h12, b0); wr_byte(8'h34, b1); bus_stop();
    chk("R1 wrong prefix nack", {31'd0, a}, 32'd0);
    chk("R1 ignored data", {17'd0, div_ratio}, 32'd0);

    // R10 write session keeps flag; R7 layout
    lock = 1'b1; port_lvl = 3'b101; adc_cmp = 4'b0011;
    read_one(d);
    chk("R7 R10 status with flag", {24'd0, d}, {24'd0, exp_status(1'b1, 1'b1, 3'b101, 4'b0011)});
    read_one(d);
    chk("R10 flag cleared by read", {24'd0, d}, {24'd0, exp_status(1'b0, 1'b1, 3'b101, 4'b0011)});

    // R3 walking ones and mixed values
    for (int k = 0; k < 15; k++) write_div(15'(1) << k);
    write_div(15'h7FFF); write_div(15'h2A55); write_div(15'h1234);

    // R4 control and port bytes
    for (int c = 0; c < 4; c++) begin
      logic [7:0] cb = 8'h80 | 8'(c * 37 + 5);
      logic [7:0] pb = 8'(c * 68 + 23);
      bus_start(); wr_byte(adr(addr_sel, 1'b0), a);
      wr_byte(cb, b0); wr_byte(pb, b1); bus_stop();
      chk("R4 ctrl", {25'd0, ctrl}, {25'd0, cb[6:0]});
      chk("R4 port", {28'd0, port_drv}, {28'd0, pb[7:4]});
      chk("R2 acks ctrl pair", {30'd0, b0, b1}, 32'd3);
      chk("R3 div untouched", {17'd0, div_ratio}, 32'h1234);
    end

    // R5 streaming pairs without re-addressing
    bus_start(); wr_byte(adr(addr_sel, 1'b0), a);
    wr_byte(8'h0F, a); wr_byte(8'hA0, a);
    wr_byte(8'hAB, a); wr_byte(8'h90, a);
    wr_byte(8'h33, a); wr_byte(8'hC3, a); bus_stop();
    chk("R5 stream div", {17'd0, div_ratio}, 32'h33C3);
    chk("R5 stream ctrl", {25'd0, ctrl}, 32'h2B);
    chk("R5 stream port", {28'd0, port_drv}, 32'h9);

    // R5 repeated start restarts pairing
    bus_start(); wr_byte(adr(addr_sel, 1'b0), a); wr_byte(8'h0A, a);
    bus_start(); wr_byte(adr(addr_sel, 1'b0), a);
    wr_byte(8'hC5, a); wr_byte(8'h30, a); bus_stop();
    chk("R5 restart div kept", {17'd0, div_ratio}, 32'h33C3);
    chk("R5 restart ctrl", {25'd0, ctrl}, 32'h45);
    chk("R5 restart port", {28'd0, port_drv}, 32'h3);

    // R6 truncated bytes
    bus_start(); wr_byte(adr(addr_sel, 1'b0), a); wr_byte(8'h11, a);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_stop();
    chk("R6 div after cut", {17'd0, div_ratio}, 32'h33C3);
    bus_start(); wr_byte(adr(addr_sel, 1'b0), a);
    for (int i = 0; i < 3; i++) bit_out(1'b1);
    bus_stop();
    chk("R6 ctrl after cut", {25'd0, ctrl}, 32'h45);
    chk("R6 port after cut", {28'd0, port_drv}, 32'h3);
    write_div(15'h0456);

    // R8 comparator sweep
    for (int t = 0; t < 16; t++) begin
      adc_cmp = 4'(t);
      read_one(d);
      chk("R8 level code", {29'd0, d[2:0]}, {29'd0, lvl_code(4'(t))});
    end

    // R7 port level and lock sweep
    for (int p = 0; p < 16; p++) begin
      port_lvl = 3'(p); lock = p[3];
      read_one(d);
      chk("R7 status", {24'd0, d}, {24'd0, exp_status(1'b0, p[3], 3'(p), adc_cmp)});
    end

    // R9 multi-byte read, then silence after nack
    lock = 1'b0; port_lvl = 3'b010; adc_cmp = 4'b0111;
    bus_start(); wr_byte(adr(addr_sel, 1'b1), a);
    rd_byte(1'b0, d); rd_byte(1'b0, d2);
    chk("R9 second byte", {16'd0, d, d2},
        {16'd0, exp_status(1'b0, 1'b0, 3'b010, 4'b0111), exp_status(1'b0, 1'b0, 3'b010, 4'b0111)});
    rd_byte(1'b1, d);
    chk("R9 third byte", {24'd0, d}, {24'd0, exp_status(1'b0, 1'b0, 3'b010, 4'b0111)});
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    chk("R9 released after nack", {24'd0, d}, 32'hFF);
    bus_stop();

    // R10 second power-on: nack alone clears the flag
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(4);
    chk("R10 div cleared", {17'd0, div_ratio}, 32'd0);
    chk("R10 ports cleared", {28'd0, port_drv}, 32'd0);
    bus_start(); wr_byte(adr(addr_sel, 1'b1), a); rd_byte(1'b1, d);
    chk("R10 flag set after reset", {31'd0, d[7]}, 32'd1);
    bus_start(); wr_byte(adr(addr_sel, 1'b1), a); rd_byte(1'b1, d);
    bus_stop();
    chk("R10 flag cleared by nack", {31'd0, d[7]}, 32'd0);
    chk("R11 idle at end", {31'd0, sda_oe}, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule